// File: doc/BRIEF.md
# Fractional Baud-Rate Divider with Deferred Commit

This block derives the 16x oversampling enable for a serial port from the system clock. The divide ratio has an integer part and a 6-bit fractional part. The integer part sets the base period in clock cycles. The fractional part adds one extra cycle to some periods. A small phase accumulator decides which periods get the extra cycle, so that the average period is `int + frac/64` cycles.

Software writes the two divisor parts into staging registers. Those writes do nothing on their own. A separate line-control write strobe copies the staged pair into a pending slot. The pending value reaches the generator at the first clock edge on which the serializer reports no character in progress. When it is applied, the generator restarts its count and its phase from zero. This prevents the bit timing from changing in the middle of a character.

Top module: `baud_frac_div`

## Requirements
- R1: After reset, both staged divisor parts and the applied divisor are zero. `baud16_tick` is low while reset is asserted. After reset is released, the tick is high on every cycle (divide by one).
- R2: When the applied integer part is 0, the tick fires on every cycle and the fractional part has no effect.
- R3: With an applied integer part N ≥ 1 and a fractional part of 0, consecutive ticks are exactly N cycles apart.
- R4: With a fractional part F, each period is N or N+1 cycles. A 6-bit accumulator starts at 0 when a divisor is applied and adds F at every tick. A period is N+1 exactly when that addition reaches 64 or more; the accumulator then keeps the sum modulo 64.
- R5: Writing the integer or fractional staging registers, with no line-control write, leaves the tick pattern unchanged.
- R6: A line-control write commits the staged values held before that edge. A staging write in the same cycle as the line-control write is not part of that commit.
- R7: While `char_busy` is high, a committed divisor is held back. It is applied at the first edge at which `char_busy` is low.
- R8: Take the edge at which the line-control write is sampled, with `char_busy` low. The divisor is applied at the next edge; no tick is issued for that apply edge. The first tick under the new divisor is high max(N,1) cycles after the apply edge.
- R9: While the applied integer part is 2 or more, `baud16_tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_wr_en | input | 1 | Write strobe for the integer staging register |
| int_wr_data | input | 16 | Integer divisor value to stage |
| frac_wr_en | input | 1 | Write strobe for the fractional staging register |
| frac_wr_data | input | 6 | Fractional divisor value to stage (units of 1/64) |
| line_wr_en | input | 1 | Line-control write strobe; commits the staged pair |
| char_busy | input | 1 | High while the serializer is inside a character |
| baud16_tick | output | 1 | Single-cycle 16x baud enable |

## Verification
The generator is run with several divisor settings. A pure integer ratio shows that the base counter is right. A fraction of 16 places the extra cycle on every fourth period, which checks when the accumulator overflows. A fraction of 63 together with an integer of 2 overflows on almost every step and keeps the pulses as close together as this range allows. An integer of zero with a nonzero fraction shows that the fraction is ignored in divide-by-one.

The update path is tested separately:
- staging writes with no commit;
- a commit in the same cycle as a staging write;
- a commit made while the serializer is busy.

These show whether the block applied too early, too late, or used the wrong staged value. The first tick after each apply is timed exactly, so that the restart of count and phase is checked.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 6;
endpackage

// File: rtl/baud_phase.sv
module baud_phase #(
  parameter int unsigned FRAC_W = baud_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  function automatic logic [FRAC_W:0] phase_sum(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  assign sum   = phase_sum(acc, frac);
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (step)   acc <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/baud_stage.sv
module baud_stage #(
  parameter int unsigned INT_W  = baud_div_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr_en,
  input  logic [INT_W-1:0]  int_wr_data,
  input  logic              frac_wr_en,
  input  logic [FRAC_W-1:0] frac_wr_data,
  input  logic              line_wr_en,
  input  logic              char_busy,
  output logic [INT_W-1:0]  pend_int,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic              apply
);
  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_frac;
  logic [FRAC_W-1:0] pend_frac;
  logic              pend_valid;

  assign apply = pend_valid && !char_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_int    <= '0;
      stg_frac   <= '0;
      pend_int   <= '0;
      pend_frac  <= '0;
      pend_valid <= 1'b0;
      act_int    <= '0;
      act_frac   <= '0;
    end else begin
      if (int_wr_en)  stg_int  <= int_wr_data;
      if (frac_wr_en) stg_frac <= frac_wr_data;
      if (line_wr_en) begin
        pend_int   <= stg_int;
        pend_frac  <= stg_frac;
        pend_valid <= 1'b1;
      end else if (apply) begin
        pend_valid <= 1'b0;
      end
      if (apply) begin
        act_int  <= pend_int;
        act_frac <= pend_frac;
      end
    end
  end

  AST_COMMIT_ONLY_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pend_int) || !$stable(pend_frac)) |-> $past(line_wr_en)); // R6
  AST_ACTIVE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_int) || !$stable(act_frac)) |-> $past(apply)); // R5
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_int) || !$stable(act_frac)) |-> !$past(char_busy)); // R7
  AST_APPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !char_busy && !line_wr_en) |=> !pend_valid); // R8
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned INT_W  = baud_div_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  load_int,
  input  logic [INT_W-1:0]  run_int,
  input  logic [FRAC_W-1:0] run_frac,
  output logic              tick
);
  logic [INT_W-1:0] cnt;
  logic             fire;
  logic             div_one;
  logic             step;
  logic             carry;

  function automatic logic [INT_W-1:0] reload(input logic [INT_W-1:0] n,
                                              input logic c);
    if (n == '0) return '0;
    return n - INT_W'(1) + INT_W'(c);
  endfunction

  assign fire    = (cnt == '0);
  assign div_one = (run_int == '0);
  assign step    = fire && !load && !div_one;

  baud_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .step  (step),
    .frac  (run_frac),
    .carry (carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (load) begin
      cnt  <= reload(load_int, 1'b0);
      tick <= 1'b0;
    end else begin
      tick <= fire;
      if (fire) cnt <= reload(run_int, carry && !div_one);
      else      cnt <= cnt - INT_W'(1);
    end
  end

  AST_DIV_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_int == '0) |-> fire); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= run_int); // R4
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_int >= INT_W'(2)) && tick |=> !tick); // R9
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int unsigned INT_W  = baud_div_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W = baud_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr_en,
  input  logic [INT_W-1:0]  int_wr_data,
  input  logic              frac_wr_en,
  input  logic [FRAC_W-1:0] frac_wr_data,
  input  logic              line_wr_en,
  input  logic              char_busy,
  output logic              baud16_tick
);
  logic [INT_W-1:0]  pend_int;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              apply;

  baud_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_wr_en    (int_wr_en),
    .int_wr_data  (int_wr_data),
    .frac_wr_en   (frac_wr_en),
    .frac_wr_data (frac_wr_data),
    .line_wr_en   (line_wr_en),
    .char_busy    (char_busy),
    .pend_int     (pend_int),
    .act_int      (act_int),
    .act_frac     (act_frac),
    .apply        (apply)
  );

  baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (apply),
    .load_int (pend_int),
    .run_int  (act_int),
    .run_frac (act_frac),
    .tick     (baud16_tick)
  );

  AST_NO_TICK_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !baud16_tick); // R8
endmodule

// File: tb/tb_baud_frac_div.sv
`timescale 1ns/1ps
module tb_baud_frac_div;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        int_wr_en;
  logic [15:0] int_wr_data;
  logic        frac_wr_en;
  logic [5:0]  frac_wr_data;
  logic        line_wr_en;
  logic        char_busy;
  logic        baud16_tick;

  int    total = 0;
  int    bad   = 0;
  int    exp_q[$];
  string req_q[$];
  int    since = 0;
  bit    armed = 1'b0;

  always #2.5 clk = ~clk;

  baud_frac_div dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_wr_en    (int_wr_en),
    .int_wr_data  (int_wr_data),
    .frac_wr_en   (frac_wr_en),
    .frac_wr_data (frac_wr_data),
    .line_wr_en   (line_wr_en),
    .char_busy    (char_busy),
    .baud16_tick  (baud16_tick)
  );

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops expected gaps, compares against observed tick spacing
  always @(negedge clk) begin
    if (armed) begin
      since++;
      if (baud16_tick) begin
        int    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e >= 0) check(since == e, r, since, e);
        since = 0;
        if (exp_q.size() == 0) armed = 1'b0;
      end
    end
  end

  // Driver side: push the gap sequence the requirements predict
  task automatic expect_div(int n, int f, int k, string req, bit wild);
    int acc = 0;
    if (wild) exp_q.push_back(-1);
    else      exp_q.push_back(((n == 0) ? 1 : n) + 1);
    req_q.push_back(req);
    for (int i = 0; i < k; i++) begin
      int g;
      if (n == 0) g = 1;
      else begin
        int s = acc + f;
        g = n + ((s >= 64) ? 1 : 0);
        acc = s % 64;
      end
      exp_q.push_back(g);
      req_q.push_back(req);
    end
    since = 0;
    armed = 1'b1;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (armed && t < 3000) begin
      @(posedge clk);
      t++;
    end
    if (armed) begin
      check(1'b0, req, exp_q.size(), 0);
      armed = 1'b0;
      exp_q.delete();
      req_q.delete();
    end
  endtask

  task automatic stage(int n, int f);
    @(negedge clk);
    int_wr_en = 1'b1; int_wr_data = 16'(n);
    frac_wr_en = 1'b1; frac_wr_data = 6'(f);
    @(negedge clk);
    int_wr_en = 1'b0; frac_wr_en = 1'b0;
  endtask

  // Returns at the edge after the commit edge (the apply edge when not busy)
  task automatic commit(bit also_int, int n);
    @(negedge clk);
    line_wr_en = 1'b1;
    if (also_int) begin int_wr_en = 1'b1; int_wr_data = 16'(n); end
    @(posedge clk);
    @(negedge clk);
    line_wr_en = 1'b0; int_wr_en = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; int_wr_en = 1'b0; int_wr_data = '0;
    frac_wr_en = 1'b0; frac_wr_data = '0; line_wr_en = 1'b0; char_busy = 1'b0;
    // R1: tick low during reset
    repeat (3) begin
      @(negedge clk);
      check(baud16_tick == 1'b0, "R1", int'(baud16_tick), 0);
    end
    rst_n = 1'b1;
    @(posedge clk);
    expect_div(0, 0, 6, "R1", 1'b1);
    drain("R1");

    // R3 and R8: integer-only ratio, exact first tick after apply
    stage(4, 0);
    commit(1'b0, 0);
    expect_div(4, 0, 5, "R3", 1'b0);
    drain("R3");

    // R4: fraction 16 gives an extra cycle every fourth period
    stage(3, 16);
    commit(1'b0, 0);
    expect_div(3, 16, 9, "R4", 1'b0);
    drain("R4");

    // R2: integer zero ignores the fraction
    stage(0, 37);
    commit(1'b0, 0);
    expect_div(0, 37, 8, "R2", 1'b0);
    drain("R2");

    // R5: staging alone leaves divide-by-one running
    stage(7, 0);
    @(posedge clk);
    expect_div(0, 0, 8, "R5", 1'b1);
    drain("R5");

    // R6: a same-cycle integer write is not part of the commit (7 applies, not 9)
    commit(1'b1, 9);
    expect_div(7, 0, 4, "R6", 1'b0);
    drain("R6");

    // R7: commit while busy keeps the old ratio, applies when busy drops
    @(negedge clk);
    char_busy = 1'b1;
    stage(5, 0);
    commit(1'b0, 0);
    expect_div(7, 0, 4, "R7", 1'b1);
    drain("R7");
    @(negedge clk);
    char_busy = 1'b0;
    @(posedge clk);
    expect_div(5, 0, 4, "R7", 1'b0);
    drain("R7");

    // R9 with R4: integer 2, fraction 63, pulses never adjacent
    stage(2, 63);
    commit(1'b0, 0);
    expect_div(2, 63, 12, "R9", 1'b0);
    drain("R9");

    // R8: back to integer only from a fractional ratio
    stage(6, 0);
    commit(1'b0, 0);
    expect_div(6, 0, 3, "R8", 1'b0);
    drain("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule